// File: doc/BRIEF.md
# Reference Clock Selector with External Synchronisation

This block generates the global reference clock of a switching converter. A fast system clock is divided down into an internal oscillator with two possible free-running rates. A single input pin selects between them and also carries synchronisation. When the pin sits at a static level, that level picks the rate: a high or floating pin gives the fast rate and a low pin gives the slow rate. When the pin carries a steady pulse train, the block detects that activity and hands the reference over to the external clock.

An inverted copy of the reference is always driven on a loop-through output. A second converter can take this copy and switch in anti-phase with the first. Changes of source take effect only at a low phase of the reference, so the output never carries a shortened high pulse. When the external train stops, the block falls back to its own oscillator.

Top module: `refclk_select`

## Requirements
- R1: While reset is asserted, `ref_clk` is 0, `sync_active` is 0 and `loop_out` is 1.
- R2: With `sync_in` held high and no activity, `ref_clk` has a period of 2*HALF_FAST system clocks, and its high phase lasts exactly HALF_FAST clocks.
- R3: With `sync_in` held low and no activity, `ref_clk` has a period of 2*HALF_SLOW system clocks, and its high phase lasts exactly HALF_SLOW clocks.
- R4: After ACQ_EDGES rising edges of `sync_in` arrive with each one within WINDOW clocks of the previous edge, `sync_active` becomes 1. From then on, `ref_clk` repeats the period and high time of `sync_in`.
- R5: A `sync_in` train whose rising edges are more than WINDOW clocks apart never sets `sync_active`.
- R6: When no rising edge of `sync_in` has arrived for WINDOW clocks, `sync_active` returns to 0 and `ref_clk` resumes internal oscillation.
- R7: `loop_out` is at all times the inverse of `ref_clk`.
- R8: A change of source happens only while `ref_clk` is low. After a change, `ref_clk` stays low until the new source is low. No high pulse is shorter than the smaller of HALF_FAST and the external high time.
- R9: The level of `sync_in` that picks the rate is re-sampled only while `sync_active` is 0. After a fallback, the rate follows the level at which the pin has settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Dual-role pin: a static level selects the rate, a pulse train acts as the external reference |
| ref_clk | output | 1 | Global reference clock |
| sync_active | output | 1 | 1 while the external train is accepted as the reference |
| loop_out | output | 1 | Inverted reference, used to drive an open-drain loop-through pin |

## Verification
The bench builds the block with HALF_FAST=3, HALF_SLOW=6, WINDOW=40 and ACQ_EDGES=3. With these values, both free-running rates, acquisition and loss of the external clock all fit within a few hundred cycles. The external half periods are drawn between 3 and 15 clocks. This keeps every edge inside the window while still allowing high phases as short as the fast oscillator's, so a runt pulse at a changeover would show up in the minimum high-time check. A train with 120-clock periods exercises the slow-input rejection.

// File: rtl/refsel_pkg.sv
`timescale 1ns/1ps
package refsel_pkg;
   typedef enum logic {SRC_INT = 1'b0, SRC_EXT = 1'b1} src_e;
endpackage

// File: rtl/refsel_sync.sv
`timescale 1ns/1ps
module refsel_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic level,
   output logic rise
);
   logic [STAGES-1:0] pipe;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("refsel_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[0] <= 1'b0;
               else        pipe[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[i] <= 1'b0;
               else        pipe[i] <= pipe[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= pipe[STAGES-1];
   end

   assign level = pipe[STAGES-1];
   assign rise  = pipe[STAGES-1] & ~prev;
endmodule

// File: rtl/refsel_osc.sv
`timescale 1ns/1ps
module refsel_osc #(
   parameter int HALF_FAST = 50,
   parameter int HALF_SLOW = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow_sel,
   output logic osc
);
   localparam int HMAX = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
   localparam int CW   = (HMAX > 1) ? $clog2(HMAX) : 1;
   localparam logic [CW-1:0] LIM_FAST = CW'(HALF_FAST - 1);
   localparam logic [CW-1:0] LIM_SLOW = CW'(HALF_SLOW - 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   generate
      if (HALF_FAST < 1 || HALF_SLOW < 1) begin : g_bad_half
         $error("refsel_osc: half periods must be positive");
      end
   endgenerate

   // The rate is latched only at a toggle, so every phase is whole.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         lim <= LIM_FAST;
         osc <= 1'b0;
      end else if (cnt == lim) begin
         cnt <= '0;
         osc <= ~osc;
         lim <= slow_sel ? LIM_SLOW : LIM_FAST;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   p_limit_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lim == LIM_FAST) || (lim == LIM_SLOW))
      else $error("limit register outside the two rates");
endmodule

// File: rtl/refsel_activity.sv
`timescale 1ns/1ps
module refsel_activity #(
   parameter int WINDOW    = 2500,
   parameter int ACQ_EDGES = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rise,
   output logic active
);
   localparam int TW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
   localparam int EW = $clog2(ACQ_EDGES + 1);
   localparam logic [TW-1:0] T_END = TW'(WINDOW - 1);
   localparam logic [EW-1:0] E_FULL = EW'(ACQ_EDGES);

   logic [TW-1:0] timer;
   logic [EW-1:0] edges;

   generate
      if (WINDOW < 2 || ACQ_EDGES < 2) begin : g_bad_window
         $error("refsel_activity: WINDOW and ACQ_EDGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timer <= '0;
         edges <= '0;
      end else if (rise) begin
         timer <= '0;
         if (edges != E_FULL) edges <= edges + 1'b1;
      end else if (timer == T_END) begin
         timer <= '0;
         edges <= '0;
      end else begin
         timer <= timer + 1'b1;
      end
   end

   assign active = (edges == E_FULL);

   p_edge_before_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> $past(rise))
      else $error("activity rose without an input edge");

   p_drop_on_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(active) |-> ($past(timer) == T_END))
      else $error("activity dropped before the window ran out");
endmodule

// File: rtl/refclk_select.sv
`timescale 1ns/1ps
module refclk_select #(
   parameter int HALF_FAST   = 50,
   parameter int HALF_SLOW   = 100,
   parameter int WINDOW      = 2500,
   parameter int ACQ_EDGES   = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_in,
   output logic ref_clk,
   output logic sync_active,
   output logic loop_out
);
   import refsel_pkg::*;

   logic sync_lvl, sync_rise, osc, active;
   logic slow_sel;
   src_e src_q, src_d;
   logic hold_q, hold_d;
   logic ref_q, ref_d, src_val;

   generate
      if (HALF_FAST == HALF_SLOW) begin : g_bad_rates
         $error("refclk_select: the two free-running rates must differ");
      end
   endgenerate

   refsel_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(sync_in),
      .level(sync_lvl), .rise(sync_rise));

   refsel_activity #(.WINDOW(WINDOW), .ACQ_EDGES(ACQ_EDGES)) u_act (
      .clk(clk), .rst_n(rst_n), .rise(sync_rise), .active(active));

   refsel_osc #(.HALF_FAST(HALF_FAST), .HALF_SLOW(HALF_SLOW)) u_osc (
      .clk(clk), .rst_n(rst_n), .slow_sel(slow_sel), .osc(osc));

   // Static level picks the rate only while no train is seen.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slow_sel <= 1'b0;
      else if (!active) slow_sel <= ~sync_lvl;
   end

   always_comb begin
      src_val = (src_q == SRC_EXT) ? sync_lvl : osc;
      src_d   = src_q;
      hold_d  = hold_q & src_val;
      ref_d   = hold_d ? 1'b0 : src_val;
      if (src_q == SRC_INT && active && ref_q && !osc) begin
         src_d  = SRC_EXT;
         hold_d = sync_lvl;
         ref_d  = 1'b0;
      end else if (src_q == SRC_EXT && !active) begin
         src_d  = SRC_INT;
         hold_d = osc;
         ref_d  = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= SRC_INT;
         hold_q <= 1'b0;
         ref_q  <= 1'b0;
      end else begin
         src_q  <= src_d;
         hold_q <= hold_d;
         ref_q  <= ref_d;
      end
   end

   assign ref_clk     = ref_q;
   assign sync_active = active;
   assign loop_out    = ~ref_q;

   p_switch_in_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (src_q != $past(src_q)) |-> !ref_q)
      else $error("source changed while reference high");

   p_hold_keeps_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      hold_q |-> !ref_q)
      else $error("reference high during changeover hold");

   p_level_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      active |=> $stable(slow_sel))
      else $error("rate selection moved while train active");
endmodule

// File: tb/refclk_select_bench.sv
`timescale 1ns/1ps
module refclk_select_bench;
   localparam int CLK_PERIOD = 10;
   localparam int HF = 3, HS = 6, WIN = 40, ACQ = 3;

   logic clk = 1'b0, rst_n = 1'b0, sync_in = 1'b1;
   logic ref_clk, sync_active, loop_out;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;
   bit drv_clocked = 1'b0;
   bit drv_level = 1'b1;
   int drv_half = 4;
   int loop_err = 0;
   int min_high = 1000, hi_run = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   refclk_select #(.HALF_FAST(HF), .HALF_SLOW(HS), .WINDOW(WIN),
                   .ACQ_EDGES(ACQ), .SYNC_STAGES(2)) u_refclk_select (
      .clk(clk), .rst_n(rst_n), .sync_in(sync_in),
      .ref_clk(ref_clk), .sync_active(sync_active), .loop_out(loop_out));

   initial begin : drive_sync
      int cnt;
      cnt = 0;
      forever begin
         @(negedge clk);
         if (drv_clocked) begin
            cnt++;
            if (cnt >= drv_half) begin sync_in = ~sync_in; cnt = 0; end
         end else begin
            sync_in = drv_level;
            cnt = 0;
         end
      end
   end

   // R7 and R8 monitors
   always @(negedge clk) begin
      if (rst_n) begin
         if (loop_out !== ~ref_clk) loop_err++;
         if (ref_clk === 1'b1) hi_run++;
         else begin
            if (hi_run > 0 && hi_run < min_high) min_high = hi_run;
            hi_run = 0;
         end
      end
   end

   function automatic int exp_period(bit lvl);
      return lvl ? 2*HF : 2*HS;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic measure(output int per, output int hi);
      while (ref_clk !== 1'b0) @(negedge clk);
      while (ref_clk !== 1'b1) @(negedge clk);
      per = 0; hi = 0;
      do begin hi++; per++; @(negedge clk); end while (ref_clk === 1'b1);
      while (ref_clk !== 1'b1) begin per++; @(negedge clk); end
   endtask

   task automatic run_static(bit lvl, string req);
      int per, hi;
      drv_clocked = 1'b0; drv_level = lvl;
      repeat (WIN + 30) @(negedge clk);
      chk(sync_active === 1'b0, {req, " active"}, sync_active, 0);
      repeat (40) @(negedge clk);
      measure(per, hi);
      chk(per == exp_period(lvl), {req, " period"}, per, exp_period(lvl));
      chk(hi == exp_period(lvl)/2, {req, " high"}, hi, exp_period(lvl)/2);
   endtask

   task automatic run_ext(int h);
      int per, hi;
      drv_half = h; drv_clocked = 1'b1;
      repeat (200) @(negedge clk);
      chk(sync_active === 1'b1, "R4 active", sync_active, 1);
      measure(per, hi);
      chk(per == 2*h, "R4 period", per, 2*h);
      chk(hi == h, "R4 high", hi, h);
   endtask

   initial begin : main
      int bad;
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      chk(ref_clk === 1'b0, "R1 ref_clk", ref_clk, 0);
      chk(sync_active === 1'b0, "R1 sync_active", sync_active, 0);
      chk(loop_out === 1'b1, "R1 loop_out", loop_out, 1);
      rst_n = 1'b1;

      run_static(1'b1, "R2");
      run_static(1'b0, "R3");
      run_ext(4);
      run_ext(3);
      for (int i = 0; i < 6; i++) run_ext(3 + int'($urandom_range(12)));
      run_static(1'b0, "R6 R9 low");
      run_ext(7);
      run_static(1'b1, "R6 R9 high");
      run_ext(15);
      run_static(1'b0, "R6 after slow ext");

      // R5: train with edges 120 clocks apart
      drv_half = 60; drv_clocked = 1'b1;
      bad = 0;
      for (int k = 0; k < 700; k++) begin
         @(negedge clk);
         if (sync_active !== 1'b0) bad++;
      end
      chk(bad == 0, "R5 slow train rejected", bad, 0);
      drv_clocked = 1'b0; drv_level = 1'b1;
      repeat (50) @(negedge clk);

      chk(loop_err == 0, "R7 loop_out inverse", loop_err, 0);
      chk(min_high >= HF, "R8 minimum high time", min_high, HF);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule